// File: doc/BRIEF.md
# Clock Source Mode Selector

This block produces a CPU clock and a system clock from one of two sources: an oscillator and a VCO whose analog loop lies outside the block. The whole block runs on one fast reference clock `clk`. Each source is presented as an edge strobe, `osc_tick` or `vco_tick`. A strobe pulses for one `clk` cycle at every edge of its source, rising or falling, so one source cycle is two strobes. The outputs `cpu_clk` and `sys_clk` are registered levels that change only on a strobe of the selected source.

Four modes are available. Direct drive passes the oscillator through. Prescaler divides the oscillator by the pre-divider and then by the post-divider. PLL divides the VCO by the post-divider. PLL base passes the VCO through. The system clock either follows the CPU clock or runs at half its rate. A new mode, divider pair and halving choice is captured on an update strobe. A switching sequencer then retires the old setting without a runt pulse and starts the new one from a known phase. While it does so, a busy flag is high.

Top module: `clksel_top`

## Requirements
- R1: While reset is low and right after it, `cpu_clk`, `sys_clk` and `busy` are 0. The block starts in direct drive with the system clock at half the CPU rate. Its first oscillator edge raises `cpu_clk`.
- R2: Mode code `mode_sel` = 0 is direct drive. The CPU clock toggles on every oscillator edge, so the division ratio is 1.
- R3: Mode code 1 is prescaler. The ratio over the oscillator is (P+1)*(K+1), where the 4-bit fields `p_sel` and `k_sel` each hold a value v that selects division by v+1.
- R4: Mode code 2 is PLL. The ratio over the VCO is K+1.
- R5: Mode code 3 is PLL base. The ratio over the VCO is 1, and the K field has no effect.
- R6: With `sys_half`=1, `sys_clk` toggles on each rising edge of `cpu_clk`. With `sys_half`=0, `sys_clk` equals `cpu_clk` while running.
- R7: For ratio N the CPU period is 2N source edges. The high phase lasts N edges when N is even or N=1. When N is odd and above 1, the high phase lasts N-1 edges, one source cycle shorter than the low phase. `cpu_clk` changes only on an edge of the selected source.
- R8: `mode_sel`, `p_sel`, `k_sel` and `sys_half` are captured only when `upd` is high while `busy` is 0. Input changes without such a strobe have no effect on the outputs. A strobe while `busy` is high is ignored.
- R9: `busy` goes high in the cycle after an accepted strobe. It falls when the new setting drives the outputs.
- R10: After a strobe, the old setting keeps running until both outputs are low. Both are then held low for 4 edges (two cycles) of the new source. The first new-source edge after `busy` falls raises `cpu_clk` with the divider at phase zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that samples the source strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse at every oscillator edge |
| vco_tick | input | 1 | One-cycle pulse at every VCO edge |
| upd | input | 1 | Capture strobe for the new setting |
| mode_sel | input | 2 | Mode code: 0 direct, 1 prescaler, 2 PLL, 3 PLL base |
| p_sel | input | 4 | Pre-divider field, ratio p_sel+1 |
| k_sel | input | 4 | Post-divider field, ratio k_sel+1 |
| sys_half | input | 1 | 1: system clock at half the CPU rate |
| cpu_clk | output | 1 | CPU clock level |
| sys_clk | output | 1 | System clock level |
| busy | output | 1 | High while a switch is in progress |

## Verification
The two functions that can meet in one cycle are the sequencer's exit from waiting (load of the new setting, outputs found low) and an edge of the old source that would advance the divider. The strobe and the two source edge streams run at unrelated spacings, so strobes land at every offset against the edges. Some strobes arrive with the outputs already low, and some arrive one edge before a fall. A scoreboard judges every case. Expected levels are computed from phase zero at the first new-source edge after `busy` falls. During the switch, the bench checks that once both outputs are low they stay low, and that a second strobe during the switch leaves the first setting in force.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  typedef enum logic [1:0] {
    MD_DIRECT = 2'd0,
    MD_PRESC  = 2'd1,
    MD_PLL    = 2'd2,
    MD_BASE   = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SW_RUN  = 2'd0,
    SW_WAIT = 2'd1,
    SW_HOLD = 2'd2
  } sw_state_e;
endpackage

// File: rtl/clksel_div.sv
// Edge-counting divider: the period is 2*ratio source edges, and the system output is derived from the CPU output.
module clksel_div #(
  parameter int NW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          clr,
  input  logic [NW-1:0] ratio,
  input  logic          half,
  output logic          cpu_o,
  output logic          sys_o
);
  localparam int CW = NW + 1;

  logic [CW-1:0] cnt, hi, last;
  logic          cpu_n;

  always_comb begin
    last  = {ratio, 1'b0} - CW'(1);
    hi    = (ratio[0] && ratio != NW'(1)) ? CW'(ratio) - CW'(1) : CW'(ratio);
    cpu_n = cnt < hi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt   <= '0;
      cpu_o <= 1'b0;
      sys_o <= 1'b0;
    end else if (run && tick) begin
      cpu_o <= cpu_n;
      cnt   <= (cnt == last) ? '0 : cnt + CW'(1);
      if (half) begin
        if (cpu_n && !cpu_o) sys_o <= !sys_o;
      end else begin
        sys_o <= cpu_n;
      end
    end
  end
endmodule

// File: rtl/clksel_seq.sv
// Switching sequencer: drain the old setting until both outputs are low, then hold them low for some new-source edges.
module clksel_seq
  import clksel_pkg::*;
#(
  parameter int HOLD_EDGES = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      upd,
  input  logic      src_tick,
  input  logic      outs_low,
  output sw_state_e st,
  output logic      load
);
  localparam int HW = $clog2(HOLD_EDGES + 1);

  logic [HW-1:0] hc;

  assign load = (st == SW_WAIT) && outs_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= SW_RUN;
      hc <= '0;
    end else begin
      unique case (st)
        SW_RUN:  if (upd) st <= SW_WAIT;
        SW_WAIT: if (outs_low) begin
          st <= SW_HOLD;
          hc <= '0;
        end
        SW_HOLD: if (src_tick) begin
          if (hc == HW'(HOLD_EDGES - 1)) st <= SW_RUN;
          else hc <= hc + HW'(1);
        end
        default: st <= SW_RUN;
      endcase
    end
  end
endmodule

// File: rtl/clksel_top.sv
module clksel_top
  import clksel_pkg::*;
#(
  parameter int DIVW       = 4,
  parameter int HOLD_EDGES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            osc_tick,
  input  logic            vco_tick,
  input  logic            upd,
  input  logic [1:0]      mode_sel,
  input  logic [DIVW-1:0] p_sel,
  input  logic [DIVW-1:0] k_sel,
  input  logic            sys_half,
  output logic            cpu_clk,
  output logic            sys_clk,
  output logic            busy
);
  localparam int NW = 2 * DIVW + 1;

  mode_e           act_mode, pend_mode;
  logic [DIVW-1:0] act_p, act_k, pend_p, pend_k;
  logic            act_half, pend_half;
  sw_state_e       st;
  logic            load, src_tick, outs_low, run;
  logic [NW-1:0]   ratio, pn, kn;

  // Pending setting is taken only from an accepted strobe; the active one only at the load point.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_mode <= MD_DIRECT;
      pend_p    <= '0;
      pend_k    <= '0;
      pend_half <= 1'b1;
      act_mode  <= MD_DIRECT;
      act_p     <= '0;
      act_k     <= '0;
      act_half  <= 1'b1;
    end else begin
      if (upd && st == SW_RUN) begin
        pend_mode <= mode_e'(mode_sel);
        pend_p    <= p_sel;
        pend_k    <= k_sel;
        pend_half <= sys_half;
      end
      if (load) begin
        act_mode <= pend_mode;
        act_p    <= pend_p;
        act_k    <= pend_k;
        act_half <= pend_half;
      end
    end
  end

  always_comb begin
    pn = NW'(act_p) + NW'(1);
    kn = NW'(act_k) + NW'(1);
    unique case (act_mode)
      MD_PRESC: ratio = pn * kn;
      MD_PLL:   ratio = kn;
      default:  ratio = NW'(1);
    endcase
    src_tick = (act_mode == MD_DIRECT || act_mode == MD_PRESC) ? osc_tick : vco_tick;
    outs_low = !cpu_clk && !sys_clk;
    run      = (st == SW_RUN) || (st == SW_WAIT && !outs_low);
  end

  clksel_seq #(.HOLD_EDGES(HOLD_EDGES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (upd),
    .src_tick (src_tick),
    .outs_low (outs_low),
    .st       (st),
    .load     (load)
  );

  clksel_div #(.NW(NW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (src_tick),
    .run   (run),
    .clr   (st == SW_HOLD),
    .ratio (ratio),
    .half  (act_half),
    .cpu_o (cpu_clk),
    .sys_o (sys_clk)
  );

  assign busy = (st != SW_RUN);
endmodule

// File: rtl/clksel_chk.sv
module clksel_chk
  import clksel_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      upd,
  input logic      osc_tick,
  input logic      vco_tick,
  input logic      busy,
  input logic      cpu,
  input logic      sys,
  input sw_state_e st,
  input logic      act_half
);
  // R10
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SW_HOLD) |-> (!cpu && !sys));

  // R9
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !busy) |=> busy);

  // R7
  edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu != $past(cpu)) |-> $past(osc_tick || vco_tick));

  // R6
  full_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SW_RUN && !act_half) |-> (sys == cpu));

  // R10
  wait_to_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SW_WAIT && !cpu && !sys) |=> (st == SW_HOLD));
endmodule

bind clksel_top clksel_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .upd      (upd),
  .osc_tick (osc_tick),
  .vco_tick (vco_tick),
  .busy     (busy),
  .cpu      (cpu_clk),
  .sys      (sys_clk),
  .st       (st),
  .act_half (act_half)
);

// File: tb/sim_clksel_top.sv
`timescale 1ns/1ps
module sim_clksel_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0, vco_tick = 1'b0, upd = 1'b0, sys_half = 1'b1;
  logic [1:0] mode_sel = 2'd0;
  logic [3:0] p_sel = 4'd0, k_sel = 4'd0;
  logic       cpu_clk, sys_clk, busy;

  int  errors = 0, checks = 0;
  bit  gen_on = 0, mon_en = 0, mon_osc = 1, done = 0;
  bit  chk_due = 0;
  logic [1:0] exp_q[$];
  string      cur_tag = "R1";

  always #2 clk = !clk;

  clksel_top u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .vco_tick(vco_tick),
    .upd(upd), .mode_sel(mode_sel), .p_sel(p_sel), .k_sel(k_sel),
    .sys_half(sys_half), .cpu_clk(cpu_clk), .sys_clk(sys_clk), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Oscillator edges every 3 cycles and VCO edges every 2 cycles: the spacings are unrelated to the strobe timing.
  initial begin
    wait (gen_on);
    forever begin
      repeat (2) @(negedge clk);
      osc_tick = 1'b1;
      @(negedge clk);
      osc_tick = 1'b0;
    end
  end
  initial begin
    wait (gen_on);
    @(negedge clk);
    forever begin
      @(negedge clk);
      vco_tick = 1'b1;
      @(negedge clk);
      vco_tick = 1'b0;
    end
  end

  // Monitor: an edge of the watched source at a posedge is checked at the following negedge.
  always @(posedge clk)
    chk_due <= mon_en && (mon_osc ? osc_tick : vco_tick) && (exp_q.size() > 0);

  always @(negedge clk) begin
    if (chk_due && exp_q.size() > 0) begin
      logic [1:0] e;
      e = exp_q.pop_front();
      check(cpu_clk == e[1], {cur_tag, " R7 cpu"}, cpu_clk, e[1]);
      check(sys_clk == e[0], {cur_tag, " R6 sys"}, sys_clk, e[0]);
    end
  end

  // Driver: push the expected levels of the first n_edges edges, starting from phase zero.
  task automatic push_expect(input int ratio, input bit half, input int n_edges);
    int  hi;
    bit  pc, s;
    hi = (ratio % 2 == 1 && ratio > 1) ? ratio - 1 : ratio;
    pc = 0;
    s  = 0;
    for (int k = 0; k < n_edges; k++) begin
      bit c;
      c = ((k % (2 * ratio)) < hi);
      if (half) begin
        if (c && !pc) s = !s;
      end else begin
        s = c;
      end
      pc = c;
      exp_q.push_back({c, s});
    end
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check(exp_q.size() == 0, {cur_tag, " drain"}, exp_q.size(), 0);
    mon_en = 0;
    @(negedge clk);
  endtask

  function automatic int ratio_of(input int m, input int p, input int k);
    case (m)
      1:       return (p + 1) * (k + 1);
      2:       return k + 1;
      default: return 1;
    endcase
  endfunction

  // Issue a switch, optionally with a second strobe during busy, then check the drain/hold and schedule the new phase.
  task automatic do_switch(input string tag, input int m, input int p, input int k,
                           input bit half, input bit second);
    bit seen_low, bad;
    int guard;
    cur_tag  = tag;
    mode_sel = 2'(m);
    p_sel    = 4'(p);
    k_sel    = 4'(k);
    sys_half = half;
    upd      = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    check(busy == 1'b1, {tag, " R9 busy after strobe"}, busy, 1);
    if (second) begin
      mode_sel = 2'd3;
      k_sel    = 4'd9;
      sys_half = !half;
      upd      = 1'b1;
      @(negedge clk);
      upd = 1'b0;
    end
    seen_low = 0;
    bad      = 0;
    guard    = 0;
    while (busy && guard < 20000) begin
      if (!cpu_clk && !sys_clk) seen_low = 1;
      else if (seen_low) bad = 1;
      @(negedge clk);
      guard++;
    end
    check(!bad, {tag, " R10 outputs stay low once low"}, bad, 0);
    check(!cpu_clk && !sys_clk, {tag, " R10 low at busy fall"}, {cpu_clk, sys_clk}, 0);
    mon_osc = (m <= 1);
    push_expect(ratio_of(m, p, k), half, 4 * ratio_of(m, p, k) + 4);
    mon_en = 1;
  endtask

  initial begin
    #600000;
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cpu_clk == 0 && sys_clk == 0, "R1 outputs in reset", {cpu_clk, sys_clk}, 0);
    check(busy == 0, "R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && cpu_clk == 0, "R1 after release", {busy, cpu_clk}, 0);
    cur_tag = "R1 R2 default";
    mon_osc = 1;
    push_expect(1, 1'b1, 16);
    mon_en = 1;
    gen_on = 1;
    drain();

    do_switch("R3 prescale P2 K1", 1, 2, 1, 1'b0, 0);
    // R8: input changes without a strobe have no effect
    repeat (5) @(negedge clk);
    mode_sel = 2'd2; p_sel = 4'd7; k_sel = 4'd0; sys_half = 1'b1;
    drain();
    check(busy == 0, "R8 no strobe keeps busy low", busy, 0);

    do_switch("R3 R7 prescale odd P0 K2", 1, 0, 2, 1'b1, 0);
    drain();
    do_switch("R4 R7 pll odd K4", 2, 0, 4, 1'b0, 0);
    drain();
    do_switch("R4 R6 pll K3 half", 2, 5, 3, 1'b1, 0);
    drain();
    do_switch("R5 base ignores K", 3, 0, 12, 1'b0, 0);
    drain();
    do_switch("R2 direct full", 0, 9, 9, 1'b0, 0);
    drain();
    do_switch("R8 strobe during busy ignored", 1, 1, 2, 1'b0, 1);
    drain();
    do_switch("R3 prescale max P15 K15", 1, 15, 15, 1'b1, 0);
    drain();
    do_switch("R2 R6 direct half", 0, 0, 0, 1'b1, 0);
    drain();
    finish_run();
  end
endmodule